// File: doc/BRIEF.md
# Serial Bus Port Status and Control Page

This block is the status and control register page of one port of a multi-speed serial bus physical layer. A host, or a remote access path carrying the same read and write strobes, sees four byte-wide words. Through these words it can set a speed limit for the port and read the port's fixed capability. It can also watch and clear failure flags, read a diagnostic error count, enable sleep and force the port's connection status to a disconnected view.

Hardware events arrive as single-cycle pulses or levels from the port logic. These events are negotiation or synchronisation failure, invalid codewords, loop-disable placement, bus reset, disconnection, the sleep and standby states, and the raw connection status. Writes take effect on the clock edge. Read data is combinational on the strobe cycle, so a clearing read returns the value held before that edge.

Top module: `port_stat_page`

## Requirements
- R1: After reset the speed limit equals the capability code (parameter, default 3 = S800). The error count, the unreliable flag, the loop-disable flag and hard disable are 0. Sleep enable takes the value of `sleep_strap` sampled in the first cycle after reset is released.
- R2: Speed codes are 000=S100, 001=S200, 010=S400, 011=S800, 100=S1600 and 101=S3200; 110 and 111 are reserved. A write to word 0 stores bits [2:0] if that code is at or below the capability. A code above the capability, including a reserved code, stores the capability code. The limit is shown at word 0 bits [2:0] and on `max_speed_o`.
- R3: While `dual_mode` is 1, the reported speed limit is 010 (S400) and writes to word 0 leave the stored limit unchanged. When `dual_mode` returns to 0, the stored limit is reported again.
- R4: Word 0 bits [5:3] always read the capability code, bit 6 always reads 1, and bit 7 reads `beta_active`.
- R5: The unreliable flag (word 1 bit 0) is set by `neg_fail` or `sync_fail`. A write to word 1 with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged. A set in the same cycle as a clearing write wins.
- R6: The 8-bit error count (word 2) increments on each `bad_code` cycle and holds at 255. A read of word 2 returns the count and clears it. A read and an increment in the same cycle return the old value and leave 1.
- R7: Sleep enable (word 1 bit 2, `sleep_en_o`) is loaded by every write to word 1 from bit 2. After the first cycle following reset, `sleep_strap` has no effect.
- R8: The loop-disable flag (word 1 bit 3) is set by `loop_set` and cleared by `bus_reset` or `disconnect`. When a clear and a set fall in the same cycle, the clear wins.
- R9: Hard disable (word 1 bit 5) is loaded by writes to word 1 from bit 5. While it is 1 and `port_disabled` is 1, `conn_o` and `rx_ok_o` (word 1 bits 6 and 7) are 0. Otherwise they follow `raw_conn` and `raw_rx_ok`.
- R10: Word 1 bit 1 reads `sleep_state` and bit 4 reads `standby_state`. Word 3 and any cycle without `rd_en` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_strap | input | 1 | Strap giving the initial sleep enable |
| dual_mode | input | 1 | Port configured as bilingual |
| beta_active | input | 1 | Port is operating in the fast mode |
| port_disabled | input | 1 | Port is disabled |
| raw_conn | input | 1 | Raw connected status |
| raw_rx_ok | input | 1 | Raw receive-OK status |
| neg_fail | input | 1 | Speed negotiation failed (pulse) |
| sync_fail | input | 1 | Synchronisation failed (pulse) |
| bad_code | input | 1 | Invalid codeword received (pulse) |
| sleep_state | input | 1 | Port is asleep |
| standby_state | input | 1 | Port is in standby |
| loop_set | input | 1 | Port placed in loop-disable (pulse) |
| bus_reset | input | 1 | Bus reset seen (pulse) |
| disconnect | input | 1 | Disconnection seen (pulse) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word select |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the strobe cycle |
| max_speed_o | output | 3 | Effective speed limit |
| sleep_en_o | output | 1 | Sleep enable |
| conn_o | output | 1 | Reported connected status |
| rx_ok_o | output | 1 | Reported receive-OK status |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a clearing read of the error count and a `bad_code` pulse. The second is a write-one-to-clear of the unreliable flag and a `sync_fail` pulse. The bench drives both members of each pair in one cycle. It then judges the outcome against its reference model: the read data must show the old count, and the next read must show 1. Separately, the flag must still read 1 after the clearing write. A third collision, `loop_set` together with `bus_reset`, must leave the loop-disable flag at 0.

// File: rtl/port_stat_pkg.sv
package port_stat_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int SPD_W  = 3;

  // word selects
  localparam logic [ADDR_W-1:0] PG_SPEED = 2'd0;
  localparam logic [ADDR_W-1:0] PG_CTRL  = 2'd1;
  localparam logic [ADDR_W-1:0] PG_ERRS  = 2'd2;

  // control word bit positions
  localparam int B_UNREL = 0;
  localparam int B_SLPST = 1;
  localparam int B_SLPEN = 2;
  localparam int B_LOOP  = 3;
  localparam int B_STBY  = 4;
  localparam int B_HARD  = 5;
  localparam int B_CONN  = 6;
  localparam int B_RXOK  = 7;

  localparam logic [SPD_W-1:0] SPD_S400    = 3'd2;
  localparam logic [SPD_W-1:0] SPD_RSV_LOW = 3'd6;
endpackage

// File: rtl/pstat_rst_sync.sv
module pstat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_i_n = sync_q[STAGES-1];
endmodule

// File: rtl/pstat_speed_reg.sv
module pstat_speed_reg
  import port_stat_pkg::*;
#(
  parameter int CAP_SPEED = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SPD_W-1:0] wr_code,
  input  logic             dual_mode,
  output logic [SPD_W-1:0] speed_o
);
  localparam logic [SPD_W-1:0] CAP_C = SPD_W'(CAP_SPEED);

  logic [SPD_W-1:0] spd_q, spd_d;
  logic             spd_en;
  logic             too_fast;

  always_comb begin
    too_fast = (wr_code > CAP_C) || (wr_code >= SPD_RSV_LOW);
    spd_d    = too_fast ? CAP_C : wr_code;
    spd_en   = wr_hit && !dual_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      spd_q <= CAP_C;
    else if (spd_en) spd_q <= spd_d;
  end

  assign speed_o = dual_mode ? SPD_S400 : spd_q;
endmodule

// File: rtl/pstat_err_cnt.sv
module pstat_err_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = bump || rd_clr;
    unique case ({rd_clr, bump})
      2'b11:   cnt_d = CNT_ONE;
      2'b10:   cnt_d = '0;
      2'b01:   cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pstat_flags.sv
module pstat_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  input  logic wr_ctrl,
  input  logic w_clr_unrel,
  input  logic w_sleep,
  input  logic w_hard,
  input  logic fail_evt,
  input  logic loop_set,
  input  logic loop_clr,
  output logic unrel_q,
  output logic sleep_q,
  output logic hard_q,
  output logic loop_q
);
  logic init_q;
  logic unrel_d, unrel_en;
  logic sleep_d, sleep_en;
  logic hard_en;
  logic loop_d, loop_en;

  always_comb begin
    unrel_en = fail_evt || (wr_ctrl && w_clr_unrel);
    unrel_d  = fail_evt;
    sleep_en = init_q || wr_ctrl;
    sleep_d  = init_q ? strap : w_sleep;
    hard_en  = wr_ctrl;
    loop_en  = loop_set || loop_clr;
    loop_d   = !loop_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_q <= 1'b1;
    else        init_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        unrel_q <= 1'b0;
    else if (unrel_en) unrel_q <= unrel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sleep_q <= 1'b0;
    else if (sleep_en) sleep_q <= sleep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hard_q <= 1'b0;
    else if (hard_en) hard_q <= w_hard;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       loop_q <= 1'b0;
    else if (loop_en) loop_q <= loop_d;
  end
endmodule

// File: rtl/port_stat_page.sv
module port_stat_page
  import port_stat_pkg::*;
#(
  parameter int CAP_SPEED = 3,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_strap,
  input  logic              dual_mode,
  input  logic              beta_active,
  input  logic              port_disabled,
  input  logic              raw_conn,
  input  logic              raw_rx_ok,
  input  logic              neg_fail,
  input  logic              sync_fail,
  input  logic              bad_code,
  input  logic              sleep_state,
  input  logic              standby_state,
  input  logic              loop_set,
  input  logic              bus_reset,
  input  logic              disconnect,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [SPD_W-1:0]  max_speed_o,
  output logic              sleep_en_o,
  output logic              conn_o,
  output logic              rx_ok_o
);
  localparam logic [SPD_W-1:0] CAP_C = SPD_W'(CAP_SPEED);

  logic             rst_i_n;
  logic             wr_speed, wr_ctrl, rd_clr;
  logic [CNT_W-1:0] err_cnt;
  logic             unrel_q, sleep_q, hard_q, loop_q;
  logic             mask_link;
  logic [DATA_W-1:0] speed_word, ctrl_word;
  logic             wdata_unused;

  assign wdata_unused = ^{wdata[7:6], wdata[4:3], wdata[1]};

  pstat_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_i_n(rst_i_n)
  );

  always_comb begin
    wr_speed = wr_en && (addr == PG_SPEED);
    wr_ctrl  = wr_en && (addr == PG_CTRL);
    rd_clr   = rd_en && (addr == PG_ERRS);
  end

  pstat_speed_reg #(.CAP_SPEED(CAP_SPEED)) u_speed (
    .clk(clk), .rst_n(rst_i_n), .wr_hit(wr_speed), .wr_code(wdata[SPD_W-1:0]),
    .dual_mode(dual_mode), .speed_o(max_speed_o)
  );

  pstat_err_cnt #(.CNT_W(CNT_W)) u_errs (
    .clk(clk), .rst_n(rst_i_n), .bump(bad_code), .rd_clr(rd_clr), .cnt_o(err_cnt)
  );

  pstat_flags u_flags (
    .clk(clk), .rst_n(rst_i_n), .strap(sleep_strap), .wr_ctrl(wr_ctrl),
    .w_clr_unrel(wdata[B_UNREL]), .w_sleep(wdata[B_SLPEN]), .w_hard(wdata[B_HARD]),
    .fail_evt(neg_fail || sync_fail), .loop_set(loop_set),
    .loop_clr(bus_reset || disconnect),
    .unrel_q(unrel_q), .sleep_q(sleep_q), .hard_q(hard_q), .loop_q(loop_q)
  );

  always_comb begin
    mask_link  = hard_q && port_disabled;
    conn_o     = raw_conn && !mask_link;
    rx_ok_o    = raw_rx_ok && !mask_link;
    sleep_en_o = sleep_q;

    speed_word = {beta_active, 1'b1, CAP_C, max_speed_o};

    ctrl_word          = '0;
    ctrl_word[B_UNREL] = unrel_q;
    ctrl_word[B_SLPST] = sleep_state;
    ctrl_word[B_SLPEN] = sleep_q;
    ctrl_word[B_LOOP]  = loop_q;
    ctrl_word[B_STBY]  = standby_state;
    ctrl_word[B_HARD]  = hard_q;
    ctrl_word[B_CONN]  = conn_o;
    ctrl_word[B_RXOK]  = rx_ok_o;

    rd_data = '0;
    if (rd_en) begin
      unique case (addr)
        PG_SPEED: rd_data = speed_word;
        PG_CTRL:  rd_data = ctrl_word;
        PG_ERRS:  rd_data = DATA_W'(err_cnt);
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/pstat_chk.sv
module pstat_chk #(
  parameter int CAP_SPEED = 3,
  parameter int CNT_W     = 8
) (
  input logic             clk,
  input logic             rst_i_n,
  input logic             dual_mode,
  input logic [2:0]       max_speed_o,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic [7:0]       rd_data,
  input logic             bad_code,
  input logic [CNT_W-1:0] err_cnt,
  input logic             neg_fail,
  input logic             sync_fail,
  input logic             unrel_q,
  input logic             bus_reset,
  input logic             disconnect,
  input logic             loop_q,
  input logic             hard_q,
  input logic             port_disabled,
  input logic             conn_o,
  input logic             rx_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [2:0]       CAP_C   = 3'(CAP_SPEED);

  assert_speed_capped_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !dual_mode |-> (max_speed_o <= CAP_C));

  assert_fixed_fields_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && addr == 2'd0) |-> (rd_data[6] && rd_data[5:3] == CAP_C));

  assert_fail_sets_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (neg_fail || sync_fail) |=> unrel_q);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (err_cnt == CNT_MAX && !(rd_en && addr == 2'd2)) |=> (err_cnt == CNT_MAX));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_en && addr == 2'd2 && !bad_code) |=> (err_cnt == '0));

  assert_loop_clear_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_reset || disconnect) |=> !loop_q);

  assert_link_masked_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (hard_q && port_disabled) |-> (!conn_o && !rx_ok_o));
endmodule

bind port_stat_page pstat_chk #(.CAP_SPEED(CAP_SPEED), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .dual_mode(dual_mode), .max_speed_o(max_speed_o),
  .rd_en(rd_en), .addr(addr), .rd_data(rd_data), .bad_code(bad_code),
  .err_cnt(err_cnt), .neg_fail(neg_fail), .sync_fail(sync_fail), .unrel_q(unrel_q),
  .bus_reset(bus_reset), .disconnect(disconnect), .loop_q(loop_q), .hard_q(hard_q),
  .port_disabled(port_disabled), .conn_o(conn_o), .rx_ok_o(rx_ok_o)
);

// File: tb/port_stat_page_test.sv
module port_stat_page_test;
  localparam int CAP = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_strap, dual_mode, beta_active, port_disabled, raw_conn, raw_rx_ok;
  logic neg_fail, sync_fail, bad_code, sleep_state, standby_state;
  logic loop_set, bus_reset, disconnect, rd_en, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rd_data;
  logic [2:0] max_speed_o;
  logic sleep_en_o, conn_o, rx_ok_o;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // reference model state
  int m_spd, m_cnt;
  bit m_unrel, m_sleep, m_loop, m_hard;

  always #5 clk = ~clk;

  port_stat_page #(.CAP_SPEED(CAP), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_strap(sleep_strap), .dual_mode(dual_mode),
    .beta_active(beta_active), .port_disabled(port_disabled), .raw_conn(raw_conn),
    .raw_rx_ok(raw_rx_ok), .neg_fail(neg_fail), .sync_fail(sync_fail),
    .bad_code(bad_code), .sleep_state(sleep_state), .standby_state(standby_state),
    .loop_set(loop_set), .bus_reset(bus_reset), .disconnect(disconnect),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .max_speed_o(max_speed_o), .sleep_en_o(sleep_en_o), .conn_o(conn_o),
    .rx_ok_o(rx_ok_o)
  );

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rd();
    int v;
    bit mask;
    mask = m_hard && port_disabled;
    if (!rd_en) return 0;
    case (addr)
      2'd0: v = (int'(beta_active) << 7) | (1 << 6) | (CAP << 3) | (dual_mode ? 2 : m_spd);
      2'd1: v = int'(m_unrel) | (int'(sleep_state) << 1) | (int'(m_sleep) << 2) |
                (int'(m_loop) << 3) | (int'(standby_state) << 4) | (int'(m_hard) << 5) |
                (int'(raw_conn && !mask) << 6) | (int'(raw_rx_ok && !mask) << 7);
      2'd2: v = m_cnt;
      default: v = 0;
    endcase
    return v;
  endfunction

  // one clock: compare all outputs, then advance the model at the edge
  task automatic cyc();
    bit mask;
    #1;
    mask = m_hard && port_disabled;
    check("rd_data", int'(rd_data), exp_rd());
    check("max_speed_o", int'(max_speed_o), dual_mode ? 2 : m_spd);
    check("sleep_en_o", int'(sleep_en_o), int'(m_sleep));
    check("conn_o", int'(conn_o), int'(raw_conn && !mask));
    check("rx_ok_o", int'(rx_ok_o), int'(raw_rx_ok && !mask));
    @(posedge clk);
    if (wr_en && addr == 2'd0 && !dual_mode)
      m_spd = (int'(wdata[2:0]) > CAP) ? CAP : int'(wdata[2:0]);
    if (neg_fail || sync_fail) m_unrel = 1'b1;
    else if (wr_en && addr == 2'd1 && wdata[0]) m_unrel = 1'b0;
    if (wr_en && addr == 2'd1) begin
      m_sleep = wdata[2];
      m_hard  = wdata[5];
    end
    if (bus_reset || disconnect) m_loop = 1'b0;
    else if (loop_set) m_loop = 1'b1;
    if (rd_en && addr == 2'd2) m_cnt = bad_code ? 1 : 0;
    else if (bad_code && m_cnt < 255) m_cnt++;
    @(negedge clk);
  endtask

  task automatic idle_all();
    neg_fail = 0; sync_fail = 0; bad_code = 0; loop_set = 0; bus_reset = 0;
    disconnect = 0; rd_en = 0; wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1; addr = a; cyc(); rd_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; cyc(); wr_en = 0; wdata = 0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; sleep_strap = 1; dual_mode = 0; beta_active = 0; port_disabled = 0;
    raw_conn = 0; raw_rx_ok = 0; sleep_state = 0; standby_state = 0;
    idle_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    m_spd = CAP; m_cnt = 0; m_unrel = 0; m_sleep = 1; m_loop = 0; m_hard = 0;

    // R1: reset state, strap captured as 1
    tag = "R1";
    rd(0); rd(1); rd(2); rd(3);
    // R7: strap ignored after the first cycle
    tag = "R7"; sleep_strap = 0; cyc(); rd(1);
    wr(1, 8'h00); rd(1); wr(1, 8'h04); rd(1);

    // R2: legal, above-capability and reserved codes
    tag = "R2";
    wr(0, 8'h01); rd(0); wr(0, 8'h05); rd(0); wr(0, 8'h00); rd(0);
    wr(0, 8'h06); rd(0); wr(0, 8'h02); rd(0); wr(0, 8'hF7); rd(0);
    wr(0, 8'h04); rd(0); wr(0, 8'h03); rd(0); wr(0, 8'h01); rd(0);

    // R3: bilingual override, write ignored, stored value returns
    tag = "R3";
    dual_mode = 1; rd(0); wr(0, 8'h00); rd(0); dual_mode = 0; rd(0);

    // R4: fixed fields and fast-mode bit
    tag = "R4"; beta_active = 1; rd(0); beta_active = 0; rd(0);

    // R5: set, write-0 no effect, W1C, collision, clear
    tag = "R5";
    neg_fail = 1; cyc(); neg_fail = 0; rd(1);
    wr(1, 8'h04); rd(1); wr(1, 8'h05); rd(1);
    sync_fail = 1; wr(1, 8'h05); sync_fail = 0; rd(1);
    wr(1, 8'h05); rd(1);

    // R6: count, clear on read, saturation, read/increment collision
    tag = "R6";
    repeat (3) begin bad_code = 1; cyc(); bad_code = 0; cyc(); end
    rd(2); rd(2);
    bad_code = 1; repeat (262) cyc(); bad_code = 0; rd(2); rd(2);
    repeat (4) begin bad_code = 1; cyc(); end
    rd_en = 1; addr = 2; cyc(); rd_en = 0; bad_code = 0;
    rd(2); rd(2);

    // R8: set, clear by bus reset, by disconnect, collision
    tag = "R8";
    loop_set = 1; cyc(); loop_set = 0; rd(1);
    bus_reset = 1; cyc(); bus_reset = 0; rd(1);
    loop_set = 1; cyc(); loop_set = 0; rd(1);
    disconnect = 1; cyc(); disconnect = 0; rd(1);
    loop_set = 1; bus_reset = 1; cyc(); loop_set = 0; bus_reset = 0; rd(1);

    // R9: masking only when hard disable and port disabled
    tag = "R9";
    raw_conn = 1; raw_rx_ok = 1; rd(1);
    wr(1, 8'h24); rd(1); port_disabled = 1; rd(1); cyc();
    raw_rx_ok = 0; rd(1); raw_rx_ok = 1;
    wr(1, 8'h04); rd(1); port_disabled = 0; rd(1);

    // R10: live state bits, unused word, no strobe
    tag = "R10";
    sleep_state = 1; rd(1); standby_state = 1; rd(1); sleep_state = 0; rd(1);
    standby_state = 0; rd(3); cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule